// File: doc/BRIEF.md
# Tagged Fully Associative Translation Cache

This block keeps a small set of recently used page mappings and turns a 24-bit virtual address into a 32-bit physical address. It does not index its storage. Every slot is compared at once against the requested page number and against an address-space tag held in a current-process register. A hit returns the frame number joined to the unchanged page offset. A miss tells the requester to fetch the mapping elsewhere. A store to a page that is not writable is refused with a protection fault.

Mappings come in through a refill port, driven by a hardware walker or by software. The refill port first rewrites a slot that already holds the same page and tag. If there is none, it takes the lowest free slot. If no slot is free, it takes the slot named by a round-robin pointer.

On a context switch, the flush input clears every slot's valid bit at once. Each slot also keeps referenced and dirty flags. These are updated after a successful access and reported alongside later translations.

Top module: `tagged_xlate_cache`

## Requirements
- R1: During and after reset, `rsp_valid` is low and no slot holds a mapping, so the first lookup returns a miss.
- R2: A request with `lk_valid` high gets exactly one response, one cycle later. On a hit, `rsp_paddr` is {frame number, `lk_vaddr[12:0]`}, and the page number is `lk_vaddr[23:13]`.
- R3: When no valid slot matches both the page number and the current process tag, the response has `rsp_miss`=1 and `rsp_hit`=0, with `rsp_paddr`, `rsp_ref` and `rsp_dirty` all zero. Exactly one of hit, miss and fault is set in every response.
- R4: A slot hits only when its tag equals the current process register. A write through `pid_wr` takes effect on lookups from the following cycle.
- R5: A store (`lk_store`=1) that matches a slot whose writable flag is 0 responds with `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0. It leaves the slot's referenced and dirty flags unchanged.
- R6: Any hit sets the slot's referenced flag, and a store hit also sets its dirty flag. `rsp_ref` and `rsp_dirty` report the flags as they were before that access, so the change shows on the next lookup.
- R7: A cycle with `flush`=1 invalidates every slot, and a refill presented in that same cycle is discarded.
- R8: A refill with no matching slot writes the lowest-indexed invalid slot. When every slot is valid, it writes the slot named by the round-robin pointer. After each such refill, the pointer moves to the slot after the one written, wrapping after the last slot.
- R9: A refill whose page number and tag match a valid slot overwrites that slot rather than adding a second copy, and it clears that slot's referenced and dirty flags.
- R10: A load that matches a slot whose writable flag is 0 hits normally.
- R11: A lookup in the same cycle as a refill sees the contents from before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pid_wr | input | 1 | Load `pid_in` into the current process register |
| pid_in | input | 8 | New current process tag |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 24 | Virtual address to translate |
| lk_store | input | 1 | 1 = store access, 0 = load |
| fill_en | input | 1 | Refill write strobe |
| fill_vpn | input | 11 | Refill page number |
| fill_pfn | input | 19 | Refill frame number |
| fill_pid | input | 8 | Refill process tag |
| fill_wr_ok | input | 1 | Refill writable flag |
| flush | input | 1 | Invalidate all slots |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 1 | Store to a non-writable page |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |
| rsp_ref | output | 1 | Referenced flag before this access (hit only) |
| rsp_dirty | output | 1 | Dirty flag before this access (hit only) |

## Verification
A wrong valid bit or tag shows up on the first lookup of that page: a hit becomes a miss, or a stale frame number comes back, one cycle after the request. A wrong round-robin pointer only shows once the store is full. The next refill then evicts the wrong page, and a later lookup of a page that should survive misses. A duplicate slot, or a lost referenced or dirty update, is caught when the next lookup reports the flags. The bench therefore fills the store completely, evicts twice, and rereads the flags after every access that should change them.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
    parameter int VA_W  = 24;
    parameter int PA_W  = 32;
    parameter int OFF_W = 13;
    parameter int PID_W = 8;
    parameter int SLOTS = 64;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(SLOTS);

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic [PID_W-1:0] pid;
        logic             dirty;
        logic             refd;
        logic             wr_ok;
        logic             live;
    } slot_t;

    function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] cur);
        if (cur == IDX_W'(SLOTS - 1)) return '0;
        return cur + 1'b1;
    endfunction
endpackage

// File: rtl/xlc_pick.sv
module xlc_pick #(
    parameter int W  = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xlc_slot_array.sv
module xlc_slot_array
    import xlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_t            wr_data,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_store,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic [PID_W-1:0] look_pid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_t            rd_slot,
    output logic [SLOTS-1:0] hit_vec,
    output logic [SLOTS-1:0] fill_vec,
    output logic [SLOTS-1:0] live_vec
);
    slot_t slot_q [SLOTS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (flush) begin
                slot_q[i].live <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                slot_q[i] <= wr_data;
            end else if (upd_en && upd_idx == IDX_W'(i)) begin
                slot_q[i].refd <= 1'b1;
                if (upd_store) slot_q[i].dirty <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign live_vec[g] = slot_q[g].live;
        assign hit_vec[g]  = slot_q[g].live && slot_q[g].vpn == look_vpn
                             && slot_q[g].pid == look_pid;
        assign fill_vec[g] = slot_q[g].live && slot_q[g].vpn == fill_vpn
                             && slot_q[g].pid == fill_pid;
    end

    assign rd_slot = slot_q[rd_idx];
endmodule

// File: rtl/xlc_victim.sv
module xlc_victim
    import xlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic             flush,
    input  logic [SLOTS-1:0] live_vec,
    input  logic [SLOTS-1:0] fill_vec,
    output logic [IDX_W-1:0] wr_idx
);
    logic             dup_any, free_any;
    logic [IDX_W-1:0] dup_idx, free_idx, ptr_q;

    xlc_pick #(.W(SLOTS)) u_dup  (.vec(fill_vec),  .any(dup_any),  .idx(dup_idx));
    xlc_pick #(.W(SLOTS)) u_free (.vec(~live_vec), .any(free_any), .idx(free_idx));

    always_comb begin
        if (dup_any)       wr_idx = dup_idx;
        else if (free_any) wr_idx = free_idx;
        else               wr_idx = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                               ptr_q <= '0;
        else if (fill_en && !flush && !dup_any) ptr_q <= next_slot(wr_idx);
    end
endmodule

// File: rtl/tagged_xlate_cache.sv
module tagged_xlate_cache
    import xlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pid_wr,
    input  logic [PID_W-1:0] pid_in,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_store,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic             fill_wr_ok,
    input  logic             flush,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_ref,
    output logic             rsp_dirty
);
    logic [PID_W-1:0] pid_q;
    logic [SLOTS-1:0] hit_vec, fill_vec, live_vec;
    logic             hit_any, deny, grant;
    logic [IDX_W-1:0] hit_idx, wr_idx;
    slot_t            rd_slot, fill_data;
    logic [VPN_W-1:0] look_vpn;

    assign look_vpn = lk_vaddr[VA_W-1:OFF_W];

    always_ff @(posedge clk) begin
        if (rst)         pid_q <= '0;
        else if (pid_wr) pid_q <= pid_in;
    end

    always_comb begin
        fill_data       = '0;
        fill_data.vpn   = fill_vpn;
        fill_data.pfn   = fill_pfn;
        fill_data.pid   = fill_pid;
        fill_data.wr_ok = fill_wr_ok;
        fill_data.live  = 1'b1;
    end

    xlc_slot_array u_arr (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_en(fill_en), .wr_idx(wr_idx), .wr_data(fill_data),
        .upd_en(grant), .upd_idx(hit_idx), .upd_store(lk_store),
        .look_vpn(look_vpn), .look_pid(pid_q),
        .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .rd_idx(hit_idx), .rd_slot(rd_slot),
        .hit_vec(hit_vec), .fill_vec(fill_vec), .live_vec(live_vec)
    );

    xlc_pick #(.W(SLOTS)) u_hit (.vec(hit_vec), .any(hit_any), .idx(hit_idx));

    xlc_victim u_vic (
        .clk(clk), .rst(rst), .fill_en(fill_en), .flush(flush),
        .live_vec(live_vec), .fill_vec(fill_vec), .wr_idx(wr_idx)
    );

    assign deny  = hit_any && lk_store && !rd_slot.wr_ok;
    assign grant = lk_valid && hit_any && !deny;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            rsp_ref   <= 1'b0;
            rsp_dirty <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= grant;
            rsp_miss  <= lk_valid && !hit_any;
            rsp_fault <= lk_valid && deny;
            rsp_paddr <= grant ? {rd_slot.pfn, lk_vaddr[OFF_W-1:0]} : '0;
            rsp_ref   <= grant && rd_slot.refd;
            rsp_dirty <= grant && rd_slot.dirty;
        end
    end
endmodule

// File: rtl/xlc_checker.sv
module xlc_checker
    import xlc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_store,
    input logic             flush,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [SLOTS-1:0] hit_vec,
    input logic [SLOTS-1:0] live_vec
);
    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);
    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
    assert_nohit_zero_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> rsp_paddr == '0);
    assert_fault_from_store_R5: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !lk_store |=> !rsp_fault);
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> live_vec == '0);
    assert_single_match_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
endmodule

bind tagged_xlate_cache xlc_checker u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_store(lk_store),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .hit_vec(hit_vec), .live_vec(live_vec)
);

// File: tb/sim_tagged_xlate_cache.sv
module sim_tagged_xlate_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pid_wr = 0, lk_valid = 0, lk_store = 0, fill_en = 0, fill_wr_ok = 0, flush = 0;
    logic [7:0]  pid_in = 0, fill_pid = 0;
    logic [23:0] lk_vaddr = 0;
    logic [10:0] fill_vpn = 0;
    logic [18:0] fill_pfn = 0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_dirty;
    logic [31:0] rsp_paddr;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic        hit, miss, fault, refd, dirty;
        logic [31:0] paddr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    tagged_xlate_cache u0 (
        .clk(clk), .rst(rst), .pid_wr(pid_wr), .pid_in(pid_in),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_store(lk_store),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_pid(fill_pid), .fill_wr_ok(fill_wr_ok), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_ref(rsp_ref),
        .rsp_dirty(rsp_dirty)
    );

    function automatic exp_t mk(input logic h, m, f, input logic [18:0] pfn,
                                input logic [12:0] off, input logic r, d, input string tag);
        exp_t e;
        e.hit = h; e.miss = m; e.fault = f; e.refd = r; e.dirty = d;
        e.paddr = h ? {pfn, off} : 32'h0;
        e.tag = tag;
        return e;
    endfunction

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response: actual valid=1 expected none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if ({rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_dirty} !== {e.hit, e.miss, e.fault, e.refd, e.dirty}
                    || rsp_paddr !== e.paddr) begin
                    errors++;
                    $display("FAIL %s: actual h/m/f/r/d=%b%b%b%b%b pa=%h expected %b%b%b%b%b pa=%h",
                             e.tag, rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_dirty, rsp_paddr,
                             e.hit, e.miss, e.fault, e.refd, e.dirty, e.paddr);
                end
            end
        end
    end

    task automatic look(input logic [10:0] vpn, input logic [12:0] off, input logic st,
                        input exp_t e);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {vpn, off}; lk_store = st;
        sb.push_back(e);
        @(negedge clk);
        lk_valid = 0; lk_store = 0;
    endtask

    task automatic fill(input logic [10:0] vpn, input logic [18:0] pfn,
                        input logic [7:0] pid, input logic w);
        @(negedge clk);
        fill_en = 1; fill_vpn = vpn; fill_pfn = pfn; fill_pid = pid; fill_wr_ok = w;
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic set_pid(input logic [7:0] p);
        @(negedge clk);
        pid_wr = 1; pid_in = p;
        @(negedge clk);
        pid_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual rsp_valid=%b expected 0", rsp_valid);
        end
        rst = 0;
        // R1 / R3: empty after reset
        look(11'd5, 13'h0abc, 0, mk(0, 1, 0, 0, 0, 0, 0, "R1 first lookup misses"));

        // R2 / R6: translation and flag reporting
        fill(11'd5, 19'h01234, 8'd0, 1);
        look(11'd5, 13'h0abc, 0, mk(1, 0, 0, 19'h01234, 13'h0abc, 0, 0, "R2 hit address"));
        look(11'd5, 13'h1fff, 1, mk(1, 0, 0, 19'h01234, 13'h1fff, 1, 0, "R6 ref set after load"));
        look(11'd5, 13'h0000, 0, mk(1, 0, 0, 19'h01234, 13'h0000, 1, 1, "R6 dirty set after store"));

        // R5 / R10: read-only page
        fill(11'd7, 19'h00022, 8'd0, 0);
        look(11'd7, 13'h0010, 1, mk(0, 0, 1, 0, 0, 0, 0, "R5 store to read-only faults"));
        look(11'd7, 13'h0010, 0, mk(1, 0, 0, 19'h00022, 13'h0010, 0, 0, "R10 load hits, R5 flags untouched"));
        look(11'd7, 13'h0011, 0, mk(1, 0, 0, 19'h00022, 13'h0011, 1, 0, "R6 ref after load"));

        // R3: unfilled page
        look(11'd9, 13'h0001, 0, mk(0, 1, 0, 0, 0, 0, 0, "R3 unknown page misses"));

        // R4: process tag
        set_pid(8'd3);
        look(11'd5, 13'h0004, 0, mk(0, 1, 0, 0, 0, 0, 0, "R4 other tag misses"));
        fill(11'd5, 19'h00777, 8'd3, 1);
        look(11'd5, 13'h0004, 0, mk(1, 0, 0, 19'h00777, 13'h0004, 0, 0, "R4 own tag hits"));
        set_pid(8'd0);
        look(11'd5, 13'h0008, 0, mk(1, 0, 0, 19'h01234, 13'h0008, 1, 1, "R4 tag 0 mapping kept"));

        // R9: refill of an existing page overwrites in place
        fill(11'd5, 19'h00999, 8'd0, 1);
        look(11'd5, 13'h0002, 0, mk(1, 0, 0, 19'h00999, 13'h0002, 0, 0, "R9 overwrite clears flags"));

        // R11: lookup concurrent with refill sees old contents
        @(negedge clk);
        fill_en = 1; fill_vpn = 11'd12; fill_pfn = 19'h00abc; fill_pid = 0; fill_wr_ok = 1;
        lk_valid = 1; lk_vaddr = {11'd12, 13'h0005}; lk_store = 0;
        sb.push_back(mk(0, 1, 0, 0, 0, 0, 0, "R11 same-cycle lookup misses"));
        @(negedge clk);
        fill_en = 0; lk_valid = 0;
        look(11'd12, 13'h0005, 0, mk(1, 0, 0, 19'h00abc, 13'h0005, 0, 0, "R11 next lookup hits"));

        // R7: flush plus dropped refill
        @(negedge clk);
        flush = 1; fill_en = 1; fill_vpn = 11'd13; fill_pfn = 19'h00013; fill_pid = 0; fill_wr_ok = 1;
        @(negedge clk);
        flush = 0; fill_en = 0;
        look(11'd5, 13'h0000, 0, mk(0, 1, 0, 0, 0, 0, 0, "R7 flushed page misses"));
        look(11'd7, 13'h0000, 0, mk(0, 1, 0, 0, 0, 0, 0, "R7 flushed read-only page misses"));
        look(11'd13, 13'h0000, 0, mk(0, 1, 0, 0, 0, 0, 0, "R7 refill during flush dropped"));
        set_pid(8'd3);
        look(11'd5, 13'h0000, 0, mk(0, 1, 0, 0, 0, 0, 0, "R7 other tag flushed too"));
        set_pid(8'd0);

        // R8: fill all slots, then round-robin eviction
        for (int i = 0; i < 64; i++) fill(11'(100 + i), 19'(1000 + i), 8'd0, 1);
        look(11'd100, 13'h0003, 0, mk(1, 0, 0, 19'd1000, 13'h0003, 0, 0, "R8 first slot present"));
        look(11'd163, 13'h0003, 0, mk(1, 0, 0, 19'd1063, 13'h0003, 0, 0, "R8 last slot present"));
        fill(11'd600, 19'h00600, 8'd0, 1);
        look(11'd100, 13'h0003, 0, mk(0, 1, 0, 0, 0, 0, 0, "R8 slot 0 evicted"));
        look(11'd101, 13'h0003, 0, mk(1, 0, 0, 19'd1001, 13'h0003, 0, 0, "R8 slot 1 kept"));
        look(11'd600, 13'h0003, 0, mk(1, 0, 0, 19'h00600, 13'h0003, 0, 0, "R8 new page hits"));
        fill(11'd601, 19'h00601, 8'd0, 1);
        look(11'd101, 13'h0003, 0, mk(0, 1, 0, 0, 0, 0, 0, "R8 pointer advanced to slot 1"));
        look(11'd102, 13'h0003, 0, mk(1, 0, 0, 19'd1002, 13'h0003, 0, 0, "R8 slot 2 kept"));
        look(11'd601, 13'h0003, 0, mk(1, 0, 0, 19'h00601, 13'h0003, 0, 0, "R8 second new page hits"));

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses: actual pending=%0d expected 0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule